// File: doc/BRIEF.md
# Message-Signalled Interrupt Capability with Per-Vector Masking

This block holds the message-signalled interrupt capability structure of one PCI function and converts interrupt events into posted memory write requests. Software programs a message address, a 16-bit message data value, an enable bit, a granted message count and a per-vector mask through a byte-enabled, dword-addressed config port. Each interrupt source raises one bit of a request vector for a cycle. The block either queues a message for that vector or, if the vector is masked, records it in a pending register that software can read.

A message carries a 64-bit address and 32-bit data. The vector number is merged into the low bits of the data, and the granted message count sets how many bits are used. Messages leave over a valid/ready handshake. When several vectors are ready at once, the lowest-numbered vector is sent first. A build parameter selects the 32-bit or the 64-bit register layout. A second parameter sets the number of vectors, from 1 to 32.

Top module: `msi_cap_unit`

## Requirements
- R1: Byte 0 of dword 0 reads 0x05 (capability identifier) and byte 1 reads the NEXT_PTR parameter; writes to either byte have no effect.
- R2: After reset, message control (bits 31:16 of dword 0) reads with bit 0 (enable) = 0, bits 6:4 (granted count exponent) = 0, bits 3:1 = the smallest n in 0..5 with 2^n >= NUM_VEC, bit 7 = 1 in the 64-bit layout, and bit 8 (masking capable) = 1.
- R3: A write to message-control byte 0 (dword 0, byte lane 2) updates only bits 0 and 6:4 and keeps bits 3:1 and 7. Writes to byte lane 3 are ignored.
- R4: Dword 1 is the low address. In the 64-bit layout dword 2 is the high address, and the message address is {high, low}. In the 32-bit layout the address is the low dword zero-extended.
- R5: Message data bits 31:16 are zero. Bits 15:0 are the programmed data (low half of the data dword: dword 3 in the 64-bit layout, dword 2 in the 32-bit layout) with its low m bits replaced by the low m bits of the vector number, where m is the granted count exponent clipped to 5. The upper half of the data dword reads zero and ignores writes.
- R6: While enabled, a request on an unmasked vector produces exactly one message and leaves that vector's pending bit clear.
- R7: While enabled, a request on a masked vector sets its pending bit and produces no message. The mask is dword 4 in the 64-bit layout (dword 3 in 32-bit); the pending register is the next dword.
- R8: A write that takes a mask bit from 1 to 0 while enabled sends that vector's message if it is pending and clears the pending bit. While disabled, the same write sends nothing and the pending bit stays set.
- R9: Request bits at 0, and all requests while disabled, produce no message and leave the pending register unchanged.
- R10: Mask and pending reset to zero. The pending register ignores config writes.
- R11: Vectors that are ready in the same cycle are issued lowest number first.
- R12: While msg_valid is high and msg_ready is low, msg_valid, msg_addr and msg_data hold their values.
- R13: A config write changes only the bytes whose byte enable is set. A read returns the addressed dword on cfg_rdata one cycle after cfg_rd.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_wr | input | 1 | Config write strobe |
| cfg_rd | input | 1 | Config read strobe |
| cfg_dw | input | 3 | Dword index inside the capability |
| cfg_be | input | 4 | Byte enables for the write |
| cfg_wdata | input | 32 | Write data |
| cfg_rdata | output | 32 | Read data, registered |
| irq_evt | input | NUM_VEC | Per-vector request, one cycle high per event |
| msg_valid | output | 1 | Message request valid |
| msg_ready | input | 1 | Downstream accepts the message |
| msg_addr | output | 64 | Message address |
| msg_data | output | 32 | Message data |

## Verification
If a pending bit is lost, nothing appears at the ports until software clears that vector's mask. At that point the expected message is missing, so the release writes in the bench are followed by an exact check of the message and of the pending readback. A corrupted queue or priority pick shows up in the order and data of the messages within a few cycles of a burst of simultaneous requests. Wrong protected control bits show up on the next read of dword 0. The bench also stalls the output to expose request fields that change before they are accepted.

// File: rtl/msi_cap_pkg.sv
package msi_cap_pkg;

  localparam logic [7:0] CAP_ID_MSI = 8'h05;

  // smallest n in 0..5 with 2**n >= count
  function automatic logic [2:0] cap_exp(input int count);
    logic [2:0] r;
    r = 3'd5;
    for (int i = 5; i >= 0; i--) begin
      if ((1 << i) >= count) r = 3'(i);
    end
    return r;
  endfunction

  // replace the low bits of the data word with the vector number
  function automatic logic [31:0] merge_data(input logic [15:0] base,
                                             input logic [2:0]  exp_g,
                                             input logic [4:0]  vec);
    logic [15:0] low_m;
    low_m = '0;
    for (int i = 0; i < 5; i++) begin
      if (i < int'(exp_g)) low_m[i] = 1'b1;
    end
    return {16'h0000, (base & ~low_m) | ({11'b0, vec} & low_m)};
  endfunction

endpackage

// File: rtl/msi_cfg_regs.sv
module msi_cfg_regs
  import msi_cap_pkg::*;
#(
  parameter int         NUM_VEC  = 8,
  parameter bit         ADDR64   = 1'b1,
  parameter logic [7:0] NEXT_PTR = 8'h00
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               cfg_wr,
  input  logic               cfg_rd,
  input  logic [2:0]         cfg_dw,
  input  logic [3:0]         cfg_be,
  input  logic [31:0]        cfg_wdata,
  output logic [31:0]        cfg_rdata,
  input  logic [NUM_VEC-1:0] pend_vec,
  output logic               msi_en,
  output logic [2:0]         grant_exp,
  output logic [63:0]        base_addr,
  output logic [15:0]        base_data,
  output logic [NUM_VEC-1:0] mask_vec,
  output logic [NUM_VEC-1:0] mask_clr
);

  localparam logic [2:0] DW_HDR  = 3'd0;
  localparam logic [2:0] DW_ALO  = 3'd1;
  localparam logic [2:0] DW_AHI  = 3'd2;
  localparam logic [2:0] DW_DATA = ADDR64 ? 3'd3 : 3'd2;
  localparam logic [2:0] DW_MASK = ADDR64 ? 3'd4 : 3'd3;
  localparam logic [2:0] DW_PEND = ADDR64 ? 3'd5 : 3'd4;
  localparam logic [2:0] CAP_EXP = cap_exp(NUM_VEC);

  logic              en_q;
  logic [2:0]        gexp_q;
  logic [31:0]       alo_q;
  logic [31:0]       ahi_q;
  logic [15:0]       data_q;
  logic [NUM_VEC-1:0] mask_q;

  logic [31:0] be_bits;
  logic [31:0] mask32;
  logic [31:0] pend32;
  logic [31:0] mask_next;
  logic [15:0] ctrl_word;
  logic [31:0] rd_word;

  always_comb begin
    be_bits = {{8{cfg_be[3]}}, {8{cfg_be[2]}}, {8{cfg_be[1]}}, {8{cfg_be[0]}}};
    mask32 = '0;
    mask32[NUM_VEC-1:0] = mask_q;
    pend32 = '0;
    pend32[NUM_VEC-1:0] = pend_vec;
    mask_next = (mask32 & ~be_bits) | (cfg_wdata & be_bits);
    mask_clr = '0;
    if (cfg_wr && cfg_dw == DW_MASK)
      mask_clr = mask_q & ~mask_next[NUM_VEC-1:0];
  end

  assign ctrl_word = {7'b0, 1'b1, ADDR64, gexp_q, CAP_EXP, en_q};

  always_comb begin
    rd_word = '0;
    if (cfg_dw == DW_HDR)
      rd_word = {ctrl_word, NEXT_PTR, CAP_ID_MSI};
    else if (cfg_dw == DW_ALO)
      rd_word = alo_q;
    else if (ADDR64 && cfg_dw == DW_AHI)
      rd_word = ahi_q;
    else if (cfg_dw == DW_DATA)
      rd_word = {16'h0000, data_q};
    else if (cfg_dw == DW_MASK)
      rd_word = mask32;
    else if (cfg_dw == DW_PEND)
      rd_word = pend32;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      en_q      <= 1'b0;
      gexp_q    <= 3'd0;
      alo_q     <= '0;
      ahi_q     <= '0;
      data_q    <= '0;
      mask_q    <= '0;
      cfg_rdata <= '0;
    end else begin
      if (cfg_rd) cfg_rdata <= rd_word;
      if (cfg_wr) begin
        if (cfg_dw == DW_HDR) begin
          // identifier and next pointer are fixed, control high byte ignored
          if (cfg_be[2]) begin
            en_q   <= cfg_wdata[16];
            gexp_q <= cfg_wdata[22:20];
          end
        end else if (cfg_dw == DW_ALO) begin
          for (int b = 0; b < 4; b++)
            if (cfg_be[b]) alo_q[8*b +: 8] <= cfg_wdata[8*b +: 8];
        end else if (ADDR64 && cfg_dw == DW_AHI) begin
          for (int b = 0; b < 4; b++)
            if (cfg_be[b]) ahi_q[8*b +: 8] <= cfg_wdata[8*b +: 8];
        end else if (cfg_dw == DW_DATA) begin
          for (int b = 0; b < 2; b++)
            if (cfg_be[b]) data_q[8*b +: 8] <= cfg_wdata[8*b +: 8];
        end else if (cfg_dw == DW_MASK) begin
          mask_q <= mask_next[NUM_VEC-1:0];
        end
      end
    end
  end

  assign msi_en    = en_q;
  assign grant_exp = gexp_q;
  assign base_addr = {ahi_q, alo_q};
  assign base_data = data_q;
  assign mask_vec  = mask_q;

endmodule

// File: rtl/msi_vec_track.sv
module msi_vec_track #(
  parameter int NUM_VEC = 8
) (
  input  logic               clk,
  input  logic               rst,
  input  logic [NUM_VEC-1:0] irq_evt,
  input  logic               msi_en,
  input  logic [NUM_VEC-1:0] mask_vec,
  input  logic [NUM_VEC-1:0] mask_clr,
  input  logic [NUM_VEC-1:0] take,
  output logic [NUM_VEC-1:0] pend_vec,
  output logic [NUM_VEC-1:0] fire_vec
);

  logic [NUM_VEC-1:0] pend_q, fire_q;
  logic [NUM_VEC-1:0] gate, eff_mask, hit_m, hit_u, rel;

  always_comb begin
    gate     = {NUM_VEC{msi_en}};
    // a bit cleared by this cycle's write counts as already unmasked
    eff_mask = mask_vec & ~mask_clr;
    hit_m    = irq_evt & gate & eff_mask;
    hit_u    = irq_evt & gate & ~eff_mask;
    rel      = mask_clr & gate & pend_q;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      pend_q <= '0;
      fire_q <= '0;
    end else begin
      pend_q <= (pend_q & ~rel & ~hit_u) | hit_m;
      fire_q <= (fire_q & ~take) | hit_u | rel;
    end
  end

  assign pend_vec = pend_q;
  assign fire_vec = fire_q;

endmodule

// File: rtl/msi_msg_issue.sv
module msi_msg_issue
  import msi_cap_pkg::*;
#(
  parameter int NUM_VEC = 8
) (
  input  logic               clk,
  input  logic               rst,
  input  logic [NUM_VEC-1:0] fire_vec,
  input  logic [63:0]        base_addr,
  input  logic [15:0]        base_data,
  input  logic [2:0]         grant_exp,
  input  logic               msg_ready,
  output logic               msg_valid,
  output logic [63:0]        msg_addr,
  output logic [31:0]        msg_data,
  output logic [NUM_VEC-1:0] take
);

  logic [NUM_VEC-1:0] pick_oh;
  logic [4:0]         pick_idx;
  logic               found;
  logic               slot_free;
  logic [2:0]         exp_clip;

  always_comb begin
    pick_oh  = '0;
    pick_idx = '0;
    found    = 1'b0;
    for (int i = 0; i < NUM_VEC; i++) begin
      if (fire_vec[i] && !found) begin
        found      = 1'b1;
        pick_idx   = 5'(i);
        pick_oh[i] = 1'b1;
      end
    end
  end

  assign slot_free = !msg_valid || msg_ready;
  assign take      = (slot_free && found) ? pick_oh : '0;
  assign exp_clip  = (grant_exp > 3'd5) ? 3'd5 : grant_exp;

  always_ff @(posedge clk) begin
    if (rst) begin
      msg_valid <= 1'b0;
      msg_addr  <= '0;
      msg_data  <= '0;
    end else if (slot_free) begin
      msg_valid <= found;
      if (found) begin
        msg_addr <= base_addr;
        msg_data <= merge_data(base_data, exp_clip, pick_idx);
      end
    end
  end

endmodule

// File: rtl/msi_cap_unit.sv
module msi_cap_unit #(
  parameter int         NUM_VEC  = 8,
  parameter bit         ADDR64   = 1'b1,
  parameter logic [7:0] NEXT_PTR = 8'h00
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               cfg_wr,
  input  logic               cfg_rd,
  input  logic [2:0]         cfg_dw,
  input  logic [3:0]         cfg_be,
  input  logic [31:0]        cfg_wdata,
  output logic [31:0]        cfg_rdata,
  input  logic [NUM_VEC-1:0] irq_evt,
  output logic               msg_valid,
  input  logic               msg_ready,
  output logic [63:0]        msg_addr,
  output logic [31:0]        msg_data
);

  if (NUM_VEC < 1 || NUM_VEC > 32) begin : g_bad_count
    $error("msi_cap_unit: NUM_VEC must lie in 1..32");
  end

  logic               msi_en;
  logic [2:0]         grant_exp;
  logic [63:0]        base_addr;
  logic [15:0]        base_data;
  logic [NUM_VEC-1:0] mask_vec, mask_clr, pend_vec, fire_vec, take;

  msi_cfg_regs #(.NUM_VEC(NUM_VEC), .ADDR64(ADDR64), .NEXT_PTR(NEXT_PTR)) u_regs (
    .clk(clk), .rst(rst), .cfg_wr(cfg_wr), .cfg_rd(cfg_rd), .cfg_dw(cfg_dw),
    .cfg_be(cfg_be), .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata),
    .pend_vec(pend_vec), .msi_en(msi_en), .grant_exp(grant_exp),
    .base_addr(base_addr), .base_data(base_data), .mask_vec(mask_vec),
    .mask_clr(mask_clr)
  );

  msi_vec_track #(.NUM_VEC(NUM_VEC)) u_track (
    .clk(clk), .rst(rst), .irq_evt(irq_evt), .msi_en(msi_en),
    .mask_vec(mask_vec), .mask_clr(mask_clr), .take(take),
    .pend_vec(pend_vec), .fire_vec(fire_vec)
  );

  msi_msg_issue #(.NUM_VEC(NUM_VEC)) u_issue (
    .clk(clk), .rst(rst), .fire_vec(fire_vec), .base_addr(base_addr),
    .base_data(base_data), .grant_exp(grant_exp), .msg_ready(msg_ready),
    .msg_valid(msg_valid), .msg_addr(msg_addr), .msg_data(msg_data),
    .take(take)
  );

endmodule

// File: rtl/msi_cap_unit_chk.sv
module msi_cap_unit_chk #(
  parameter int NUM_VEC = 8,
  parameter bit ADDR64  = 1'b1
) (
  input logic               clk,
  input logic               rst,
  input logic               msg_valid,
  input logic               msg_ready,
  input logic [63:0]        msg_addr,
  input logic [31:0]        msg_data,
  input logic [NUM_VEC-1:0] irq_evt,
  input logic               msi_en,
  input logic [NUM_VEC-1:0] mask_vec,
  input logic [NUM_VEC-1:0] mask_clr,
  input logic [NUM_VEC-1:0] pend_vec
);

  assert_hold_stall_R12: assert property (@(posedge clk) disable iff (rst)
    (msg_valid && !msg_ready) |=> (msg_valid && $stable(msg_addr) && $stable(msg_data)));

  assert_data_upper_zero_R5: assert property (@(posedge clk) disable iff (rst)
    msg_valid |-> (msg_data[31:16] == 16'h0000));

  assert_addr_narrow_R4: assert property (@(posedge clk) disable iff (rst)
    (!ADDR64 && msg_valid) |-> (msg_addr[63:32] == 32'h0));

  assert_masked_sets_pend_R7: assert property (@(posedge clk) disable iff (rst)
    (msi_en && ((irq_evt & mask_vec & ~mask_clr) != '0))
    |=> (($past(irq_evt & mask_vec & ~mask_clr) & ~pend_vec) == '0));

  assert_disabled_pend_hold_R9: assert property (@(posedge clk) disable iff (rst)
    !msi_en |=> (pend_vec == $past(pend_vec)));

endmodule

bind msi_cap_unit msi_cap_unit_chk #(.NUM_VEC(NUM_VEC), .ADDR64(ADDR64)) u_chk (
  .clk(clk), .rst(rst), .msg_valid(msg_valid), .msg_ready(msg_ready),
  .msg_addr(msg_addr), .msg_data(msg_data), .irq_evt(irq_evt),
  .msi_en(msi_en), .mask_vec(mask_vec), .mask_clr(mask_clr),
  .pend_vec(pend_vec)
);

// File: tb/msi_cap_unit_bench.sv
`timescale 1ns/1ps
module msi_cap_unit_bench;

  localparam int         NV   = 8;
  localparam logic [7:0] NXT  = 8'h48;
  localparam logic [2:0] DWM  = 3'd4;
  localparam logic [2:0] DWP  = 3'd5;
  localparam logic [63:0] ADR = 64'h0000_0001_FEE0_ABCD;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          cfg_wr = 1'b0, cfg_rd = 1'b0;
  logic [2:0]    cfg_dw = '0;
  logic [3:0]    cfg_be = '0;
  logic [31:0]   cfg_wdata = '0;
  logic [31:0]   cfg_rdata;
  logic [NV-1:0] irq_evt = '0;
  logic          msg_valid;
  logic          msg_ready = 1'b1;
  logic [63:0]   msg_addr;
  logic [31:0]   msg_data;

  int total = 0;
  int bad   = 0;
  int cyc   = 0;
  bit done  = 1'b0;

  always #2.5 clk = ~clk;

  msi_cap_unit #(.NUM_VEC(NV), .ADDR64(1'b1), .NEXT_PTR(NXT)) u_msi_cap_unit (
    .clk(clk), .rst(rst), .cfg_wr(cfg_wr), .cfg_rd(cfg_rd), .cfg_dw(cfg_dw),
    .cfg_be(cfg_be), .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata),
    .irq_evt(irq_evt), .msg_valid(msg_valid), .msg_ready(msg_ready),
    .msg_addr(msg_addr), .msg_data(msg_data)
  );

  task automatic check(input string tag, input logic [63:0] act, input logic [63:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic cfg_write(input logic [2:0] dw, input logic [3:0] be, input logic [31:0] d);
    @(negedge clk);
    cfg_wr = 1'b1; cfg_dw = dw; cfg_be = be; cfg_wdata = d;
    @(negedge clk);
    cfg_wr = 1'b0; cfg_be = '0;
  endtask

  task automatic cfg_read(input logic [2:0] dw, output logic [31:0] d);
    @(negedge clk);
    cfg_rd = 1'b1; cfg_dw = dw;
    @(negedge clk);
    cfg_rd = 1'b0;
    d = cfg_rdata;
  endtask

  task automatic read_check(input string tag, input logic [2:0] dw, input logic [31:0] exp);
    logic [31:0] d;
    cfg_read(dw, d);
    check(tag, {32'h0, d}, {32'h0, exp});
  endtask

  task automatic pulse(input logic [NV-1:0] v);
    @(negedge clk);
    irq_evt = v;
    @(negedge clk);
    irq_evt = '0;
  endtask

  // called at a negedge; waits for a message and checks it
  task automatic expect_msg(input string tag, input logic [63:0] a, input logic [31:0] d);
    int n = 0;
    while (!msg_valid && n < 20) begin
      @(negedge clk);
      n++;
    end
    check({tag, " valid"}, {63'h0, msg_valid}, 64'h1);
    check({tag, " addr"}, msg_addr, a);
    check({tag, " data"}, {32'h0, msg_data}, {32'h0, d});
    @(negedge clk);
  endtask

  task automatic expect_none(input string tag, input int cycles);
    logic seen = 1'b0;
    for (int i = 0; i < cycles; i++) begin
      @(negedge clk);
      if (msg_valid) seen = 1'b1;
    end
    check({tag, " no message"}, {63'h0, seen}, 64'h0);
  endtask

  task automatic t_reset();
    read_check("R1 R2 header after reset", 3'd0, {16'h0186, NXT, 8'h05});
    read_check("R10 mask reset", DWM, 32'h0);
    read_check("R10 pending reset", DWP, 32'h0);
    expect_none("R9 idle after reset", 4);
  endtask

  task automatic t_ctrl();
    cfg_write(3'd0, 4'hF, 32'hFFFF_FFFF);
    read_check("R3 R1 all-ones write", 3'd0, {16'h01F7, NXT, 8'h05});
    cfg_write(3'd0, 4'hF, 32'h0000_0000);
    read_check("R3 all-zeros write", 3'd0, {16'h0186, NXT, 8'h05});
    cfg_write(3'd0, 4'b0100, 32'h0031_0000);
    read_check("R3 enable and count", 3'd0, {16'h01B7, NXT, 8'h05});
  endtask

  task automatic t_addr();
    cfg_write(3'd1, 4'hF, 32'hFEE0_1000);
    cfg_write(3'd1, 4'b0011, 32'hAAAA_ABCD);
    read_check("R13 partial byte enables", 3'd1, 32'hFEE0_ABCD);
    cfg_write(3'd2, 4'hF, 32'h0000_0001);
    read_check("R4 high address", 3'd2, 32'h0000_0001);
    cfg_write(3'd3, 4'hF, 32'h1234_5678);
    read_check("R5 data upper half ignored", 3'd3, 32'h0000_5678);
  endtask

  task automatic t_send();
    pulse(8'b0010_0000);
    expect_msg("R6 R4 R5 vector 5", ADR, 32'h0000_567D);
    read_check("R6 pending stays clear", DWP, 32'h0);
    expect_none("R6 single message", 4);
  endtask

  task automatic t_exp();
    cfg_write(3'd0, 4'b0100, 32'h0001_0000);
    pulse(8'b0010_0000);
    expect_msg("R5 zero exponent", ADR, 32'h0000_5678);
    cfg_write(3'd0, 4'b0100, 32'h0051_0000);
    pulse(8'b0100_0000);
    expect_msg("R5 exponent five", ADR, 32'h0000_5666);
    cfg_write(3'd0, 4'b0100, 32'h0071_0000);
    pulse(8'b0100_0000);
    expect_msg("R5 exponent clipped", ADR, 32'h0000_5666);
    cfg_write(3'd0, 4'b0100, 32'h0031_0000);
  endtask

  task automatic t_mask();
    cfg_write(DWM, 4'hF, 32'h0000_0024);
    pulse(8'b0010_0100);
    expect_none("R7 masked vectors", 5);
    read_check("R7 pending set", DWP, 32'h0000_0024);
    cfg_write(DWP, 4'hF, 32'h0000_0000);
    read_check("R10 pending ignores writes", DWP, 32'h0000_0024);
    cfg_write(DWM, 4'b0001, 32'h0000_0004);
    expect_msg("R8 release vector 5", ADR, 32'h0000_567D);
    read_check("R8 pending after release", DWP, 32'h0000_0004);
    cfg_write(3'd0, 4'b0100, 32'h0030_0000);
    cfg_write(DWM, 4'b0001, 32'h0000_0000);
    expect_none("R8 release while disabled", 5);
    read_check("R8 pending kept while disabled", DWP, 32'h0000_0004);
    pulse(8'b0000_1000);
    expect_none("R9 request while disabled", 5);
    read_check("R9 pending unchanged", DWP, 32'h0000_0004);
    cfg_write(3'd0, 4'b0100, 32'h0031_0000);
    expect_none("R9 low requests", 5);
    cfg_write(DWM, 4'b0001, 32'h0000_0004);
    cfg_write(DWM, 4'b0001, 32'h0000_0000);
    expect_msg("R8 late release vector 2", ADR, 32'h0000_567A);
    read_check("R8 pending cleared", DWP, 32'h0);
  endtask

  task automatic t_prio();
    logic [31:0] d0;
    @(negedge clk);
    msg_ready = 1'b0;
    pulse(8'b0100_1010);
    @(negedge clk);
    check("R12 valid under stall", {63'h0, msg_valid}, 64'h1);
    d0 = msg_data;
    check("R11 first pick is vector 1", {32'h0, d0}, {32'h0, 32'h0000_5679});
    for (int i = 0; i < 3; i++) begin
      @(negedge clk);
      check("R12 data held", {32'h0, msg_data}, {32'h0, d0});
    end
    msg_ready = 1'b1;
    expect_msg("R11 order vector 1", ADR, 32'h0000_5679);
    expect_msg("R11 order vector 3", ADR, 32'h0000_567B);
    expect_msg("R11 order vector 6", ADR, 32'h0000_567E);
    expect_none("R11 queue drained", 4);
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 20000 && !done) begin
      done = 1'b1;
      total++;
      bad++;
      $display("FAIL watchdog: actual=%0d cycles expected=<20000", cyc);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    t_reset();
    t_ctrl();
    t_addr();
    t_send();
    t_exp();
    t_mask();
    t_prio();
    if (!done) begin
      done = 1'b1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

endmodule